// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one processor transfer at a time over an address/data bus whose lines are shared between address and data. An execution core presents a request: address, direction, memory or I/O space, and write data. It then pulses a start line. The controller walks four fixed phases, T1 to T4. It strobes the external address latch in T1, drives the command strobes and the select lines, stretches the transfer with wait phases while the target holds READY low, and pulses done to the core when the cycle closes.

The controller also shares the bus with another master through a HOLD/HLDA handshake. A hold request is honoured only between cycles. While the bus is granted, every address, data and control output is released through its output-enable. The pad ring is expected to turn the enables into tri-state drivers.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle: `ale`=0, `rd_n`=1, `wr_n`=1, `hlda`=0, `req_done`=0, `ad_oe`=0, `ctl_oe`=1, `req_rdata`=0.
- R2: A `req_start` seen high at a clock edge while idle, with `hold` low, starts T1 on the next clock. During T1, `ale`=1 for exactly one clock, `ad_oe`=1 and `ad_out` carries the request address.
- R3: `mio` (1 = memory space, 0 = I/O space) and `dtr` (1 = controller transmits, i.e. write) equal the request's space and direction from T1 through T4.
- R4: The command strobe is low in T2, T3 and every wait phase, and high in T1 and T4. For a read this is `rd_n`; for a write it is `wr_n`. The other strobe stays high throughout.
- R5: `ready` is sampled at the end of T3 and of each wait phase. While it is low, wait phases are inserted before T4, so a cycle with N low samples lasts 4+N clocks.
- R6: In a write, `ad_oe`=1 and `ad_out` carries the write data, zero-extended, from T2 through T4. In a read, `ad_oe`=0 after T1, and `ad_in` is captured into `req_rdata` at the edge that ends the phase where `ready` is high. `req_rdata` then holds that value.
- R7: `req_done` is high for exactly one clock, during T4. With `ready` high it is high on the fourth clock after the start edge.
- R8: `hold` is sampled at every edge. When idle, `hlda` rises on the next clock and beats a simultaneous start. During a cycle, `hlda` rises on the clock after T4. While `hlda`=1, `ctl_oe`=0 and `ad_oe`=0.
- R9: While `hlda`=1 no cycle starts and `req_start` is ignored. After `hold` is seen low, `hlda` falls and `ctl_oe` returns on the next clock, with no T1 in that clock.
- R10: `req_start` raised while a cycle is in progress is ignored and starts no second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Core requests a transfer |
| req_addr | input | AW | Transfer address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wdata | input | DW | Write data |
| req_done | output | 1 | One-clock pulse in T4 |
| req_rdata | output | DW | Captured read data |
| ad_out | output | AW | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Enable for the shared lines |
| ad_in | input | DW | Shared data lines, incoming value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read command, active low |
| wr_n | output | 1 | Write command, active low |
| mio | output | 1 | Memory/I/O select |
| dtr | output | 1 | Data direction, 1 = transmit |
| ctl_oe | output | 1 | Enable for control outputs |
| ready | input | 1 | Target ready |
| hold | input | 1 | External master bus request |
| hlda | output | 1 | Bus grant to the external master |

## Verification
The assertions check properties that hold on every clock. The latch strobe lasts one clock and never overlaps a command strobe. Read and write strobes are never low together. Done is a single-clock pulse and always follows a high READY sample. A granted bus has all enables off, and the grant only follows a sampled request. The bench scenarios cover the rest: the exact phase in which each output changes, the data on the shared lines, the captured read value, the number of wait phases, and that a start is ignored during a cycle or a hold.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5,
      PH_HELD = 3'd6
   } phase_e;
endpackage

// File: rtl/mbs_seq.sv
// Phase sequencer with the hold arbitration folded into its cycle boundaries.
module mbs_seq
   import mbs_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   ready,
   input  logic   hold,
   output logic   accept,
   output phase_e ph
);
   phase_e ph_nxt;

   assign accept = (ph == PH_IDLE) && start && !hold;

   always_comb begin
      ph_nxt = ph;
      unique case (ph)
         PH_IDLE: begin
            if (hold)       ph_nxt = PH_HELD;
            else if (start) ph_nxt = PH_T1;
         end
         PH_T1:   ph_nxt = PH_T2;
         PH_T2:   ph_nxt = PH_T3;
         PH_T3,
         PH_TW:   ph_nxt = ready ? PH_T4 : PH_TW;
         PH_T4:   ph_nxt = hold ? PH_HELD : PH_IDLE;
         PH_HELD: ph_nxt = hold ? PH_HELD : PH_IDLE;
         default: ph_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_IDLE;
      else        ph <= ph_nxt;
   end
endmodule

// File: rtl/mbs_req_latch.sv
// Holds the accepted request and captures read data.
module mbs_req_latch #(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic          mem,
   input  logic [DW-1:0] wdata,
   input  logic          capture,
   input  logic [DW-1:0] ad_in,
   output logic [AW-1:0] q_addr,
   output logic          q_wr,
   output logic          q_mem,
   output logic [DW-1:0] q_wdata,
   output logic [DW-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_wr    <= 1'b0;
         q_mem   <= 1'b0;
         q_wdata <= '0;
      end else if (load) begin
         q_addr  <= addr;
         q_wr    <= wr;
         q_mem   <= mem;
         q_wdata <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= ad_in;
   end
endmodule

// File: rtl/mbs_pad.sv
// Decodes the phase into the bus pins and their output-enables.
module mbs_pad
   import mbs_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input  phase_e        ph,
   input  logic [AW-1:0] q_addr,
   input  logic          q_wr,
   input  logic          q_mem,
   input  logic [DW-1:0] q_wdata,
   output logic [AW-1:0] ad_out,
   output logic          ad_oe,
   output logic          ale,
   output logic          rd_n,
   output logic          wr_n,
   output logic          mio,
   output logic          dtr,
   output logic          ctl_oe,
   output logic          hlda,
   output logic          done
);
   localparam int PAD = AW - DW;

   logic [AW-1:0] wd_ext;
   logic          in_cmd;
   logic          in_data;

   generate
      if (PAD == 0) begin : g_same
         assign wd_ext = q_wdata;
      end else begin : g_pad
         assign wd_ext = {{PAD{1'b0}}, q_wdata};
      end
   endgenerate

   assign in_cmd  = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
   assign in_data = in_cmd || (ph == PH_T4);

   assign ale    = (ph == PH_T1);
   assign ad_out = (ph == PH_T1) ? q_addr : wd_ext;
   assign ad_oe  = ale || (q_wr && in_data);
   assign rd_n   = !(in_cmd && !q_wr);
   assign wr_n   = !(in_cmd && q_wr);
   assign mio    = q_mem;
   assign dtr    = q_wr;
   assign hlda   = (ph == PH_HELD);
   assign ctl_oe = !hlda;
   assign done   = (ph == PH_T4);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic [AW-1:0] req_addr,
   input  logic          req_wr,
   input  logic          req_mem,
   input  logic [DW-1:0] req_wdata,
   output logic          req_done,
   output logic [DW-1:0] req_rdata,
   output logic [AW-1:0] ad_out,
   output logic          ad_oe,
   input  logic [DW-1:0] ad_in,
   output logic          ale,
   output logic          rd_n,
   output logic          wr_n,
   output logic          mio,
   output logic          dtr,
   output logic          ctl_oe,
   input  logic          ready,
   input  logic          hold,
   output logic          hlda
);
   generate
      if (DW < 1 || AW < DW) begin : g_bad_width
         $error("mux_bus_seq: need 1 <= DW <= AW");
      end
   endgenerate

   phase_e        ph;
   logic          accept;
   logic          capture;
   logic [AW-1:0] q_addr;
   logic          q_wr;
   logic          q_mem;
   logic [DW-1:0] q_wdata;

   mbs_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (req_start),
      .ready  (ready),
      .hold   (hold),
      .accept (accept),
      .ph     (ph)
   );

   assign capture = !q_wr && ready && ((ph == PH_T3) || (ph == PH_TW));

   mbs_req_latch #(.AW(AW), .DW(DW)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .addr    (req_addr),
      .wr      (req_wr),
      .mem     (req_mem),
      .wdata   (req_wdata),
      .capture (capture),
      .ad_in   (ad_in),
      .q_addr  (q_addr),
      .q_wr    (q_wr),
      .q_mem   (q_mem),
      .q_wdata (q_wdata),
      .rdata   (req_rdata)
   );

   mbs_pad #(.AW(AW), .DW(DW)) u_pad (
      .ph      (ph),
      .q_addr  (q_addr),
      .q_wr    (q_wr),
      .q_mem   (q_mem),
      .q_wdata (q_wdata),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .ale     (ale),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .mio     (mio),
      .dtr     (dtr),
      .ctl_oe  (ctl_oe),
      .hlda    (hlda),
      .done    (req_done)
   );
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk (
   input logic clk,
   input logic rst_n,
   input logic req_done,
   input logic ad_oe,
   input logic ale,
   input logic rd_n,
   input logic wr_n,
   input logic ctl_oe,
   input logic ready,
   input logic hold,
   input logic hlda
);
   a_r2_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);
   a_r4_ale_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n));
   a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);
   a_r5_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_done) |-> $past(ready));
   a_r8_grant_floats: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!ctl_oe && !ad_oe));
   a_r8_grant_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda) |-> $past(hold));
   a_r9_no_cycle_granted: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!ale && rd_n && wr_n));
endmodule

bind mux_bus_seq mbs_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_done (req_done),
   .ad_oe    (ad_oe),
   .ale      (ale),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .ctl_oe   (ctl_oe),
   .ready    (ready),
   .hold     (hold),
   .hlda     (hlda)
);

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
   localparam int AW = 20;
   localparam int DW = 16;
   localparam int VW = 1 + 1 + 3 + 1 + 1 + AW + 2 * DW;
   localparam int NV = 6;

   // {wr, mem, nwait, extra_start, hold_at_t2, addr, wdata, rdata}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 20'hABCDE, 16'h0000, 16'h5A5A},
      {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 20'h003F8, 16'h1234, 16'h0000},
      {1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 20'h00060, 16'h0000, 16'hC3E1},
      {1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 20'hFFFF0, 16'hBEEF, 16'h0000},
      {1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 20'h12345, 16'h0000, 16'h7E81},
      {1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 20'h320F8, 16'h9ABC, 16'h0000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_start = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_wr = 1'b0;
   logic          req_mem = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_done;
   logic [DW-1:0] req_rdata;
   logic [AW-1:0] ad_out;
   logic          ad_oe;
   logic [DW-1:0] ad_in = '0;
   logic          ale, rd_n, wr_n, mio, dtr, ctl_oe, hlda;
   logic          ready = 1'b1;
   logic          hold = 1'b0;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   mux_bus_seq #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
      .req_wr(req_wr), .req_mem(req_mem), .req_wdata(req_wdata),
      .req_done(req_done), .req_rdata(req_rdata), .ad_out(ad_out),
      .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .mio(mio), .dtr(dtr), .ctl_oe(ctl_oe), .ready(ready), .hold(hold),
      .hlda(hlda)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, what, act, exp);
   endtask

   // Entered just after a negedge with the controller idle.
   task automatic run_cycle(input logic [VW-1:0] v);
      logic          wr, mem, xs, hf;
      logic [2:0]    nw;
      logic [AW-1:0] a;
      logic [DW-1:0] wd, rd;
      logic          cmd_n;
      {wr, mem, nw, xs, hf, a, wd, rd} = v;
      req_start = 1'b1; req_addr = a; req_wr = wr; req_mem = mem;
      req_wdata = wd; ready = 1'b1; hold = 1'b0; ad_in = ~rd;
      @(negedge clk); // T1
      req_start = 1'b0;
      chk_eq("R2", "ale in T1", ale, 1);
      chk_eq("R2", "ad_oe in T1", ad_oe, 1);
      chk_eq("R2", "address in T1", ad_out, a);
      chk_eq("R3", "mio in T1", mio, mem);
      chk_eq("R3", "dtr in T1", dtr, wr);
      chk_eq("R4", "strobes high in T1", {rd_n, wr_n}, 2'b11);
      @(negedge clk); // T2
      cmd_n = wr ? wr_n : rd_n;
      chk_eq("R2", "ale low in T2", ale, 0);
      chk_eq("R4", "strobe low in T2", cmd_n, 0);
      chk_eq("R4", "other strobe in T2", wr ? rd_n : wr_n, 1);
      chk_eq("R6", "ad_oe in T2", ad_oe, wr);
      if (wr) chk_eq("R6", "write data in T2", ad_out, {{(AW-DW){1'b0}}, wd});
      if (xs) req_start = 1'b1;
      if (hf) hold = 1'b1;
      @(negedge clk); // T3
      req_start = 1'b0;
      for (int k = 0; k <= int'(nw); k++) begin
         cmd_n = wr ? wr_n : rd_n;
         chk_eq("R5", "strobe low in T3/Tw", cmd_n, 0);
         chk_eq("R7", "no done before T4", req_done, 0);
         chk_eq("R3", "mio held", mio, mem);
         chk_eq("R8", "no grant mid-cycle", hlda, 0);
         if (!wr) chk_eq("R6", "read releases lines", ad_oe, 0);
         ready = (k == int'(nw));
         ad_in = (k == int'(nw)) ? rd : ~rd;
         @(negedge clk);
      end
      // T4
      ready = 1'b1;
      chk_eq("R7", "done in T4", req_done, 1);
      chk_eq("R4", "strobes high in T4", {rd_n, wr_n}, 2'b11);
      chk_eq("R3", "dtr held in T4", dtr, wr);
      chk_eq("R8", "no grant in T4", hlda, 0);
      chk_eq("R6", "ad_oe in T4", ad_oe, wr);
      if (!wr) chk_eq("R6", "read data captured", req_rdata, rd);
      ad_in = ~rd;
      @(negedge clk);
      chk_eq("R7", "done one clock", req_done, 0);
      if (hf) begin
         chk_eq("R8", "grant after T4", hlda, 1);
         chk_eq("R8", "control floated", ctl_oe, 0);
         chk_eq("R8", "lines floated", ad_oe, 0);
         req_start = 1'b1;
         @(negedge clk);
         chk_eq("R9", "no T1 while granted", ale, 0);
         chk_eq("R9", "grant kept", hlda, 1);
         hold = 1'b0;
         @(negedge clk);
         chk_eq("R9", "grant released", hlda, 0);
         chk_eq("R9", "control driven again", ctl_oe, 1);
         chk_eq("R9", "no T1 on release clock", ale, 0);
         @(negedge clk);
         chk_eq("R2", "start accepted after release", ale, 1);
         req_start = 1'b0;
         @(negedge clk);
         @(negedge clk);
         ready = 1'b1;
         @(negedge clk);
         @(negedge clk); // back to idle after the follow-on cycle
      end else begin
         chk_eq("R6", "lines released when idle", ad_oe, 0);
         if (!wr) chk_eq("R6", "read data held", req_rdata, rd);
         if (xs) begin
            @(negedge clk);
            chk_eq("R10", "mid-cycle start ignored", ale, 0);
         end
      end
   endtask

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_eq("R1", "ale", ale, 0);
      chk_eq("R1", "strobes", {rd_n, wr_n}, 2'b11);
      chk_eq("R1", "hlda", hlda, 0);
      chk_eq("R1", "done", req_done, 0);
      chk_eq("R1", "ad_oe", ad_oe, 0);
      chk_eq("R1", "ctl_oe", ctl_oe, 1);
      chk_eq("R1", "rdata", req_rdata, 0);

      for (int i = 0; i < NV; i++) run_cycle(VEC[i]);

      // R8 hold from idle beats a simultaneous start
      hold = 1'b1;
      req_start = 1'b1;
      @(negedge clk);
      chk_eq("R8", "grant from idle", hlda, 1);
      chk_eq("R8", "hold beats start", ale, 0);
      chk_eq("R8", "lines floated from idle", {ctl_oe, ad_oe}, 2'b00);
      req_start = 1'b0;
      hold = 1'b0;
      @(negedge clk);
      chk_eq("R9", "release from idle grant", hlda, 0);
      @(negedge clk);
      chk_eq("R9", "stays idle", ale, 0);

      // R7 done timing: start edge -> done on fourth clock
      req_start = 1'b1; req_wr = 1'b0; ready = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      repeat (2) @(negedge clk);
      chk_eq("R7", "no done in T3", req_done, 0);
      @(negedge clk);
      chk_eq("R7", "done on fourth clock", req_done, 1);
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule